// File: doc/BRIEF.md
# ASCII Hex Record Loader

This block turns a stream of printable hex records into memory writes. Characters come in one per beat on an 8-bit input qualified by a valid strobe. Each record opens with a colon and then carries, as pairs of hex digits, a data byte count, a big-endian load address, a record type, the data bytes and a closing checksum byte. Every completed data byte leaves the block as a single-cycle write strobe together with its address and value. The memory that receives these writes lies outside the block.

Two sticky flags report trouble. One flags a record whose bytes do not sum to zero modulo 256. The other flags a malformed record: a bad character, a colon in the middle of a record, an oversized count or an unknown type. A record is final either when its type is 01 or when its count is 00. When a final record closes with a good checksum, the done output rises and the block then ignores all further input until reset.

Top module: `hexrec_loader`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, wr_en, csum_err, fmt_err and done are all low.
- R2: A character is consumed only on a cycle where char_valid is high. Outside a record, every character except a colon (0x3A) is ignored and raises no flag.
- R3: A record consists of a colon and then these two-digit hex fields: count, address high byte, address low byte, type 00, count data bytes, checksum. Data byte i is written to address+i modulo 2^16. wr_en is high for exactly the one cycle after the beat that carried the byte's second digit, with wr_addr and wr_data valid in that cycle.
- R4: Hex digits 0-9, A-F and a-f are all accepted with the same values, and the two cases may be mixed.
- R5: A count above 0x10 sets fmt_err. The rest of that record produces no writes.
- R6: A type other than 00 or 01, or type 01 with a nonzero count, sets fmt_err and produces no writes.
- R7: A character that is neither a hex digit nor a colon inside a record sets fmt_err and makes the block ignore input up to the next colon. A colon inside a record also sets fmt_err, but it starts a new record at once.
- R8: If count + address bytes + type + data bytes + checksum is not 0 modulo 256, csum_err is set. The bytes of that record have already been written and stay written.
- R9: A record is final when its type is 01 or its count is 00. done rises on the cycle after the final record's last checksum digit, provided the checksum is correct. A final record with a bad checksum leaves done low, and parsing continues.
- R10: Once done is high, no further write is issued and fmt_err and csum_err no longer change, whatever characters arrive.
- R11: fmt_err, csum_err and done, once set, stay high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_valid | input | 1 | char_data holds a character this cycle |
| char_data | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle write strobe for a data byte |
| wr_addr | output | ADDR_W | Address of the byte being written |
| wr_data | output | 8 | Data byte being written |
| csum_err | output | 1 | Sticky checksum mismatch flag |
| fmt_err | output | 1 | Sticky malformed-record flag |
| done | output | 1 | Final record accepted, held until reset |

## Verification
The main stimulus sweeps every legal count from 1 to 16. Records alternate between upper and lower case digits, and one record wraps the address past 0xFFFF. This separates count handling, address increment and digit decoding, and each write is compared with an address and value computed in the bench. Separate scenarios feed stray characters before a colon, an oversized count, unknown and inconsistent types, a bad character in the middle of a record and a colon in the middle of a record. The checksum is skewed on both a data record and a final record. These patterns tell apart the rules for flagging, the rules for resynchronising and the rules for which writes are kept. Both forms of final record are tried, and input sent after done shows that the block has gone silent.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_ADDR,
        ST_TYPE,
        ST_DATA,
        ST_CSUM,
        ST_DONE
    } ldr_state_e;

    localparam logic [7:0] CH_COLON  = 8'h3A;
    localparam logic [7:0] TYPE_DATA = 8'h00;
    localparam logic [7:0] TYPE_END  = 8'h01;

endpackage

// File: rtl/hexrec_char_class.sv
module hexrec_char_class (
    input  logic [7:0] ch,
    output logic       is_colon,
    output logic       is_hex,
    output logic [3:0] nib
);
    logic is_num;
    logic is_alpha;

    always_comb begin
        is_colon = (ch == hexrec_pkg::CH_COLON);
        is_num   = (ch >= 8'h30) && (ch <= 8'h39);
        is_alpha = ((ch >= 8'h41) && (ch <= 8'h46)) || ((ch >= 8'h61) && (ch <= 8'h66));
        is_hex   = is_num || is_alpha;
        nib      = is_num ? ch[3:0] : (ch[3:0] + 4'd9);
    end
endmodule

// File: rtl/hexrec_csum_acc.sv
module hexrec_csum_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    output logic [W-1:0] total
);
    logic [W-1:0] acc_d, acc_q;

    always_comb begin
        total = acc_q + add_val;
        acc_d = acc_q;
        if (clr)
            acc_d = '0;
        else if (add_en)
            acc_d = total;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader #(
    parameter int ADDR_W   = 16,
    parameter int MAX_DATA = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [7:0]        char_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              csum_err,
    output logic              fmt_err,
    output logic              done
);
    import hexrec_pkg::*;

    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int IDX_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int CNT_W      = $clog2(MAX_DATA + 1);
    localparam logic [7:0]       MAX_CNT   = 8'(MAX_DATA);
    localparam logic [IDX_W-1:0] LAST_ABYTE = IDX_W'(ADDR_BYTES - 1);

    typedef struct packed {
        ldr_state_e        st;
        logic [3:0]        hi;
        logic              half;
        logic [IDX_W-1:0]  abyte;
        logic [7:0]        count;
        logic [CNT_W-1:0]  left;
        logic              is_final;
        logic [ADDR_W-1:0] addr;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [7:0]        wr_data;
        logic              csum_err;
        logic              fmt_err;
        logic              done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic       is_colon, is_hex;
    logic [3:0] nib;
    logic [7:0] byte_val;
    logic [7:0] sum_total;
    logic       sum_clr, sum_add;

    hexrec_char_class u_class (
        .ch       (char_data),
        .is_colon (is_colon),
        .is_hex   (is_hex),
        .nib      (nib)
    );

    hexrec_csum_acc #(.W(8)) u_csum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sum_clr),
        .add_en  (sum_add),
        .add_val (byte_val),
        .total   (sum_total)
    );

    assign byte_val = {c_q.hi, nib};

    always_comb begin
        c_d       = c_q;
        c_d.wr_en = 1'b0;
        sum_clr   = 1'b0;
        sum_add   = 1'b0;

        if (char_valid && (c_q.st != ST_DONE)) begin
            if (is_colon) begin
                if (c_q.st != ST_IDLE) c_d.fmt_err = 1'b1;
                c_d.st   = ST_COUNT;
                c_d.half = 1'b0;
                sum_clr  = 1'b1;
            end else if (c_q.st == ST_IDLE) begin
                c_d.st = ST_IDLE;
            end else if (!is_hex) begin
                c_d.fmt_err = 1'b1;
                c_d.st      = ST_IDLE;
            end else if (!c_q.half) begin
                c_d.hi   = nib;
                c_d.half = 1'b1;
            end else begin
                c_d.half = 1'b0;
                sum_add  = 1'b1;
                unique case (c_q.st)
                    ST_COUNT: begin
                        if (byte_val > MAX_CNT) begin
                            c_d.fmt_err = 1'b1;
                            c_d.st      = ST_IDLE;
                        end else begin
                            c_d.count = byte_val;
                            c_d.left  = byte_val[CNT_W-1:0];
                            c_d.abyte = '0;
                            c_d.st    = ST_ADDR;
                        end
                    end
                    ST_ADDR: begin
                        c_d.addr = {c_q.addr[ADDR_W-9:0], byte_val};
                        if (c_q.abyte == LAST_ABYTE) c_d.st = ST_TYPE;
                        else                         c_d.abyte = c_q.abyte + 1'b1;
                    end
                    ST_TYPE: begin
                        if (byte_val == TYPE_DATA) begin
                            c_d.is_final = (c_q.count == 8'h00);
                            c_d.st       = (c_q.count == 8'h00) ? ST_CSUM : ST_DATA;
                        end else if ((byte_val == TYPE_END) && (c_q.count == 8'h00)) begin
                            c_d.is_final = 1'b1;
                            c_d.st       = ST_CSUM;
                        end else begin
                            c_d.fmt_err = 1'b1;
                            c_d.st      = ST_IDLE;
                        end
                    end
                    ST_DATA: begin
                        c_d.wr_en   = 1'b1;
                        c_d.wr_addr = c_q.addr;
                        c_d.wr_data = byte_val;
                        c_d.addr    = c_q.addr + 1'b1;
                        c_d.left    = c_q.left - 1'b1;
                        if (c_q.left == CNT_W'(1)) c_d.st = ST_CSUM;
                    end
                    ST_CSUM: begin
                        if (sum_total != 8'h00) begin
                            c_d.csum_err = 1'b1;
                            c_d.st       = ST_IDLE;
                        end else if (c_q.is_final) begin
                            c_d.done = 1'b1;
                            c_d.st   = ST_DONE;
                        end else begin
                            c_d.st = ST_IDLE;
                        end
                    end
                    default: c_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign wr_en    = c_q.wr_en;
    assign wr_addr  = c_q.wr_addr;
    assign wr_data  = c_q.wr_data;
    assign csum_err = c_q.csum_err;
    assign fmt_err  = c_q.fmt_err;
    assign done     = c_q.done;
endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic char_valid,
    input logic wr_en,
    input logic csum_err,
    input logic fmt_err,
    input logic done
);
    // R3: a write strobe is always caused by a consumed character
    p_write_follows_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(char_valid));

    // R9: done only rises on a consumed character
    p_done_needs_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(char_valid));

    // R7: a format flag only rises on a consumed character
    p_fmt_needs_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fmt_err) |-> $past(char_valid));

    // R10: no writes once done
    p_silent_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wr_en);

    // R10: flags frozen once done
    p_flags_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(fmt_err) && $stable(csum_err)));

    // R11: sticky outputs
    p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    p_csum_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        csum_err |=> csum_err);
    p_fmt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err);
endmodule

bind hexrec_loader hexrec_loader_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_valid (char_valid),
    .wr_en      (wr_en),
    .csum_err   (csum_err),
    .fmt_err    (fmt_err),
    .done       (done)
);

// File: tb/hexrec_loader_test.sv
`timescale 1ns/1ps
module hexrec_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_valid = 1'b0;
    logic [7:0]  char_data = 8'h00;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        csum_err, fmt_err, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hexrec_loader uut (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .csum_err(csum_err), .fmt_err(fmt_err), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        char_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(input logic [7:0] c);
        @(negedge clk);
        char_data  = c;
        char_valid = 1'b1;
        @(negedge clk);
        char_valid = 1'b0;
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        return (lower ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
    endfunction

    task automatic send_byte(input logic [7:0] b, input bit lower, input bit exp_wr,
                             input logic [15:0] exp_addr, input string req);
        put(hexc(b[7:4], lower));
        check(wr_en == 1'b0, req, "wr_en after high digit", int'(wr_en), 0);
        put(hexc(b[3:0], !lower));
        if (exp_wr) begin
            check(wr_en == 1'b1, req, "wr_en", int'(wr_en), 1);
            check(wr_addr == exp_addr, req, "wr_addr", int'(wr_addr), int'(exp_addr));
            check(wr_data == b, req, "wr_data", int'(wr_data), int'(b));
        end else begin
            check(wr_en == 1'b0, req, "wr_en idle", int'(wr_en), 0);
        end
    endtask

    function automatic logic [7:0] dbyte(input int seed, input int i);
        return 8'(seed * 13 + i * 29 + 5);
    endfunction

    // colon plus count, address and type; returns running sum
    task automatic rec_head(input logic [7:0] cnt, input logic [15:0] a, input logic [7:0] typ,
                            input bit lower, input string req, output logic [7:0] sum);
        put(8'h3A);
        send_byte(cnt, lower, 1'b0, 16'h0, req);
        send_byte(a[15:8], lower, 1'b0, 16'h0, req);
        send_byte(a[7:0], lower, 1'b0, 16'h0, req);
        send_byte(typ, lower, 1'b0, 16'h0, req);
        sum = cnt + a[15:8] + a[7:0] + typ;
    endtask

    task automatic send_rec(input int cnt, input logic [15:0] a, input logic [7:0] typ,
                            input int seed, input bit lower, input logic [7:0] cs_skew,
                            input bit exp_wr, input string req);
        logic [7:0] sum;
        rec_head(8'(cnt), a, typ, lower, req, sum);
        for (int i = 0; i < cnt; i++) begin
            send_byte(dbyte(seed, i), lower, exp_wr, a + 16'(i), req);
            sum = sum + dbyte(seed, i);
        end
        send_byte(8'(~sum + 8'd1) + cs_skew, lower, 1'b0, 16'h0, req);
    endtask

    initial begin
        logic [7:0] s;
        do_reset();
        // R1 reset state
        check(wr_en == 0, "R1", "wr_en", int'(wr_en), 0);
        check(csum_err == 0, "R1", "csum_err", int'(csum_err), 0);
        check(fmt_err == 0, "R1", "fmt_err", int'(fmt_err), 0);
        check(done == 0, "R1", "done", int'(done), 0);

        // R2 stray characters outside a record
        put("x"); put(8'h0D); put("5"); put("A"); put("G");
        check(wr_en == 0 && fmt_err == 0, "R2", "stray chars", int'(fmt_err), 0);
        repeat (5) @(negedge clk);
        send_rec(2, 16'h0100, 8'h00, 99, 1'b0, 8'h00, 1'b1, "R2");
        check(fmt_err == 0 && csum_err == 0, "R2", "flags after record", int'(fmt_err), 0);

        // R3 / R4 sweep of counts, alternating case
        for (int n = 1; n <= 16; n++) begin
            send_rec(n, 16'(n * 16'h0111 + 16'h0040), 8'h00, n, (n % 2) == 1, 8'h00, 1'b1,
                     (n % 2) ? "R4" : "R3");
            check(csum_err == 0 && fmt_err == 0, "R3", "flags in sweep", int'(csum_err), 0);
        end
        // R3 address wrap
        send_rec(16, 16'hFFF8, 8'h00, 77, 1'b1, 8'h00, 1'b1, "R3");
        check(csum_err == 0 && fmt_err == 0 && done == 0, "R3", "flags after wrap", int'(done), 0);

        // R5 oversized count
        do_reset();
        send_rec(17, 16'h2000, 8'h00, 3, 1'b0, 8'h00, 1'b0, "R5");
        check(fmt_err == 1, "R5", "fmt_err", int'(fmt_err), 1);

        // R6 unknown type, and end type with data
        do_reset();
        send_rec(1, 16'h2100, 8'h02, 4, 1'b0, 8'h00, 1'b0, "R6");
        check(fmt_err == 1, "R6", "fmt_err type 02", int'(fmt_err), 1);
        do_reset();
        send_rec(2, 16'h2200, 8'h01, 5, 1'b0, 8'h00, 1'b0, "R6");
        check(fmt_err == 1 && done == 0, "R6", "fmt_err type 01 count 2", int'(fmt_err), 1);

        // R7 bad character mid record, then resync
        do_reset();
        rec_head(8'h04, 16'h3000, 8'h00, 1'b0, "R7", s);
        send_byte(8'h5A, 1'b0, 1'b1, 16'h3000, "R7");
        put("G");
        check(fmt_err == 1, "R7", "fmt_err on bad char", int'(fmt_err), 1);
        send_byte(8'h12, 1'b0, 1'b0, 16'h0, "R7");
        send_byte(8'h34, 1'b0, 1'b0, 16'h0, "R7");
        send_rec(2, 16'h3100, 8'h00, 6, 1'b0, 8'h00, 1'b1, "R7");
        check(csum_err == 0, "R7", "resync csum", int'(csum_err), 0);
        // R7 colon mid record restarts
        do_reset();
        put(8'h3A);
        send_byte(8'h10, 1'b0, 1'b0, 16'h0, "R7");
        send_byte(8'h40, 1'b0, 1'b0, 16'h0, "R7");
        send_rec(1, 16'h4000, 8'h00, 7, 1'b1, 8'h00, 1'b1, "R7");
        check(fmt_err == 1 && csum_err == 0, "R7", "colon restart", int'(fmt_err), 1);

        // R8 checksum mismatch, writes kept; R11 sticky
        do_reset();
        send_rec(3, 16'h5000, 8'h00, 8, 1'b0, 8'h01, 1'b1, "R8");
        check(csum_err == 1 && done == 0, "R8", "csum_err", int'(csum_err), 1);
        send_rec(1, 16'h5100, 8'h00, 9, 1'b0, 8'h00, 1'b1, "R11");
        check(csum_err == 1, "R11", "csum_err sticky", int'(csum_err), 1);

        // R9 final by type 01, timing of done
        do_reset();
        rec_head(8'h00, 16'h0000, 8'h01, 1'b0, "R9", s);
        put("F");
        check(done == 0, "R9", "done before last digit", int'(done), 0);
        put("F");
        check(done == 1, "R9", "done after end record", int'(done), 1);
        // R10 ignore after done
        send_rec(2, 16'h6000, 8'h00, 10, 1'b0, 8'h00, 1'b0, "R10");
        put("G");
        check(done == 1 && fmt_err == 0 && csum_err == 0, "R10", "flags after done",
              int'(fmt_err), 0);
        repeat (10) @(negedge clk);
        check(done == 1, "R11", "done held", int'(done), 1);

        // R9 final by zero count with type 00
        do_reset();
        send_rec(0, 16'h1234, 8'h00, 0, 1'b1, 8'h00, 1'b0, "R9");
        check(done == 1, "R9", "done zero-count", int'(done), 1);

        // R9 final with bad checksum, then good one
        do_reset();
        send_rec(0, 16'h0000, 8'h01, 0, 1'b0, 8'h05, 1'b0, "R9");
        check(done == 0 && csum_err == 1, "R9", "bad final", int'(done), 0);
        send_rec(1, 16'h7000, 8'h00, 11, 1'b0, 8'h00, 1'b1, "R9");
        send_rec(0, 16'h0000, 8'h01, 0, 1'b0, 8'h00, 1'b0, "R9");
        check(done == 1, "R9", "good final after bad", int'(done), 1);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule